// File: doc/BRIEF.md
# Interleaved Address to Device Offset Decoder

This block turns an offset inside an interleaved memory region into two results: the index of the target device that owns the offset, and the offset inside that device. The interleave set is described by two small codes. One code gives the way count. It covers power-of-two sets of 1, 2, 4, 8 or 16 devices, and sets of 3, 6 or 12 devices. The other code gives the granularity, which is 256 bytes shifted left by the code.

For power-of-two sets, the target index is a bit field of the offset. The device offset is the host offset with that field removed. Sets built on three cannot be sliced like this. For them the target index is a remainder modulo the way count, and the upper part of the device offset is a quotient by three. A small serial divider produces both. One request is taken through a valid/ready handshake. Every request, of any mode, finishes after the same fixed number of cycles with a one-cycle done pulse. An encoding that is not supported gives an error flag instead of a result.

Top module: `ilv_decoder`

## Requirements
- R1: After reset `in_ready` is 1 and `out_valid` is 0. `in_ready` goes low on the edge that accepts a request and stays low through the done cycle. It is 1 again in the cycle after the done pulse.
- R2: `out_valid` is high for exactly one cycle. With default parameters it rises 13 clock edges after the accepting edge (ceil(ADDR_W/STEP)), whatever the mode or the validity of the codes.
- R3: For a valid request, device offset bits [eig+7:0] equal host offset bits [eig+7:0].
- R4: For way code eiw in 1..4 (2^eiw ways), `out_pos` equals host offset bits [eig+8+eiw-1 : eig+8].
- R5: For way code eiw in 1..4, device offset bits from eig+8 upward equal host offset bits [51 : eig+eiw+8] shifted right by eiw.
- R6: Way code 0 (one way) gives `out_pos` = 0 and a device offset equal to the host offset.
- R7: For way codes 8, 9 and 10 (3, 6 and 12 ways), `out_pos` equals (host offset >> (eig+8)) modulo the way count.
- R8: For way codes 8, 9 and 10, device offset bits from eig+8 upward equal (host offset >> (eig+eiw)) / 3.
- R9: Way codes 5, 6, 7 and 11 to 15 give `out_err` = 1, `out_dpa` all ones and `out_pos` = 0.
- R10: Granularity codes 7 to 15 give the same error result as R9. Codes 0 to 6 are valid.
- R11: A request offered while the block is busy is not taken and does not change the result under way. The results stay unchanged after the done pulse until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Block idle, request may be taken |
| in_hpa | input | 52 | Host offset within the region |
| in_eiw | input | 4 | Way-count code |
| in_eig | input | 4 | Granularity code |
| out_valid | output | 1 | One-cycle done pulse |
| out_err | output | 1 | Codes were not supported |
| out_pos | output | 4 | Target index |
| out_dpa | output | 52 | Offset inside the target device |

## Verification
Every result is due in the cycle after the thirteenth rising edge that follows the accepting edge. This holds even for power-of-two and error requests, because all modes share one schedule. The bench counts falling edges from the accept and requires the done pulse on exactly the thirteenth one. It samples position, offset and error flag at that point, one half-period away from any edge. On the next falling edge it checks that the pulse has dropped and that `in_ready` is back. The hold and busy checks sample the same outputs a few cycles later or earlier than the done point.

// File: rtl/ilvd_pkg.sv
package ilvd_pkg;

    localparam int POS_W = 4;

    typedef logic [3:0] eiw_t;
    typedef logic [3:0] eig_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } dec_state_t;

    // ok: code supported; three: set built on 3; pw: power-of-two factor log2
    typedef struct packed {
        logic       ok;
        logic       three;
        logic [2:0] pw;
    } way_info_t;

    function automatic way_info_t decode_way_code(eiw_t code);
        way_info_t w;
        w.ok    = 1'b0;
        w.three = 1'b0;
        w.pw    = 3'd0;
        if (code <= 4'd4) begin
            w.ok = 1'b1;
            w.pw = code[2:0];
        end else if (code >= 4'd8 && code <= 4'd10) begin
            w.ok    = 1'b1;
            w.three = 1'b1;
            w.pw    = 3'(code - 4'd8);
        end
        return w;
    endfunction

    function automatic logic gran_code_ok(eig_t code);
        return code <= 4'd6;
    endfunction

    function automatic logic [4:0] way_count(way_info_t w);
        return w.three ? (5'd3 << w.pw) : (5'd1 << w.pw);
    endfunction

endpackage

// File: rtl/ilvd_param_check.sv
module ilvd_param_check
    import ilvd_pkg::*;
(
    input  eiw_t      eiw,
    input  eig_t      eig,
    output way_info_t winfo,
    output logic      bad
);
    way_info_t w;

    always_comb begin
        w     = decode_way_code(eiw);
        winfo = w;
        bad   = !w.ok || !gran_code_ok(eig);
    end

endmodule

// File: rtl/ilvd_pow2_slice.sv
module ilvd_pow2_slice
    import ilvd_pkg::*;
#(
    parameter int ADDR_W = 52
) (
    input  logic [ADDR_W-1:0] hpa,
    input  logic [2:0]        pw,
    input  eig_t              eig,
    output logic [POS_W-1:0]  pos,
    output logic [ADDR_W-1:0] dpa
);
    logic [5:0]        gsh;
    logic [5:0]        upsh;
    logic [ADDR_W-1:0] lo_mask;
    logic [ADDR_W-1:0] up_mask;
    logic [ADDR_W-1:0] field;

    always_comb begin
        gsh     = 6'(eig) + 6'd8;
        upsh    = gsh + 6'(pw);
        lo_mask = ~({ADDR_W{1'b1}} << gsh);
        up_mask = {ADDR_W{1'b1}} << upsh;
        field   = hpa >> gsh;
        pos     = field[POS_W-1:0] & POS_W'((5'd1 << pw) - 5'd1);
        dpa     = ((hpa & up_mask) >> pw) | (hpa & lo_mask);
    end

endmodule

// File: rtl/ilvd_div3_seq.sv
module ilvd_div3_seq #(
    parameter int W    = 52,
    parameter int STEP = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] din,
    input  logic         step_en,
    output logic [W-1:0] quo,
    output logic [1:0]   rem
);
    localparam int ITER = (W + STEP - 1) / STEP;
    localparam int PAD  = ITER * STEP;

    logic [PAD-1:0] dvd_q, quo_q;
    logic [1:0]     rem_q;
    logic [PAD-1:0] dvd_n, quo_n;
    logic [1:0]     rem_n;
    logic [2:0]     part;

    always_comb begin
        dvd_n = dvd_q;
        quo_n = quo_q;
        rem_n = rem_q;
        part  = 3'd0;
        for (int i = 0; i < STEP; i++) begin
            part  = {rem_n, dvd_n[PAD-1]};
            dvd_n = {dvd_n[PAD-2:0], 1'b0};
            if (part >= 3'd3) begin
                rem_n = 2'(part - 3'd3);
                quo_n = {quo_n[PAD-2:0], 1'b1};
            end else begin
                rem_n = part[1:0];
                quo_n = {quo_n[PAD-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dvd_q <= '0;
            quo_q <= '0;
            rem_q <= '0;
        end else if (load) begin
            dvd_q <= PAD'(din);
            quo_q <= '0;
            rem_q <= '0;
        end else if (step_en) begin
            dvd_q <= dvd_n;
            quo_q <= quo_n;
            rem_q <= rem_n;
        end
    end

    assign quo = quo_q[W-1:0];
    assign rem = rem_q;

    // R8: partial remainder of a divide by three never reaches three
    a_r8_rem_below_three: assert property (@(posedge clk) disable iff (rst)
        rem_q != 2'd3);

endmodule

// File: rtl/ilv_decoder.sv
module ilv_decoder
    import ilvd_pkg::*;
#(
    parameter int ADDR_W = 52,
    parameter int STEP   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ADDR_W-1:0] in_hpa,
    input  logic [3:0]        in_eiw,
    input  logic [3:0]        in_eig,
    output logic              out_valid,
    output logic              out_err,
    output logic [POS_W-1:0]  out_pos,
    output logic [ADDR_W-1:0] out_dpa
);
    localparam int ITER  = (ADDR_W + STEP - 1) / STEP;
    localparam int CNT_W = $clog2(ITER + 1);

    dec_state_t        state;
    logic [CNT_W-1:0]  cnt;
    logic              accept;

    logic [ADDR_W-1:0] hpa_q;
    eig_t              eig_q;
    way_info_t         winfo_q;
    logic              err_q;

    way_info_t         winfo_in;
    logic              bad_in;

    logic [5:0]        dsh;
    logic [ADDR_W-1:0] div_in;
    logic [ADDR_W-1:0] quo;
    logic [1:0]        rem;

    logic [POS_W-1:0]  p2_pos;
    logic [ADDR_W-1:0] p2_dpa;

    logic [5:0]        gsh;
    logic [ADDR_W-1:0] lo_mask;
    logic [ADDR_W-1:0] field;
    logic [POS_W-1:0]  t_pos;
    logic [ADDR_W-1:0] t_dpa;

    assign in_ready  = (state == ST_IDLE);
    assign accept    = in_valid && in_ready;
    assign out_valid = (state == ST_DONE);

    ilvd_param_check u_check (
        .eiw   (in_eiw),
        .eig   (in_eig),
        .winfo (winfo_in),
        .bad   (bad_in)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            hpa_q   <= '0;
            eig_q   <= '0;
            winfo_q <= '0;
            err_q   <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (accept) begin
                    state   <= ST_RUN;
                    cnt     <= '0;
                    hpa_q   <= in_hpa;
                    eig_q   <= in_eig;
                    winfo_q <= winfo_in;
                    err_q   <= bad_in;
                end
                ST_RUN: begin
                    if (cnt == CNT_W'(ITER - 1)) state <= ST_DONE;
                    else                         cnt   <= cnt + 1'b1;
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // dividend: host offset above the way and granule bits
    assign dsh    = 6'(in_eig) + 6'(in_eiw);
    assign div_in = in_hpa >> dsh;

    ilvd_div3_seq #(.W(ADDR_W), .STEP(STEP)) u_div3 (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .din     (div_in),
        .step_en (state == ST_RUN),
        .quo     (quo),
        .rem     (rem)
    );

    ilvd_pow2_slice #(.ADDR_W(ADDR_W)) u_slice (
        .hpa (hpa_q),
        .pw  (winfo_q.pw),
        .eig (eig_q),
        .pos (p2_pos),
        .dpa (p2_dpa)
    );

    // three-based: pos = (rem << k) | low k bits of the granule index
    always_comb begin
        gsh     = 6'(eig_q) + 6'd8;
        lo_mask = ~({ADDR_W{1'b1}} << gsh);
        field   = hpa_q >> gsh;
        t_pos   = (POS_W'(rem) << winfo_q.pw)
                | (field[POS_W-1:0] & POS_W'((5'd1 << winfo_q.pw) - 5'd1));
        t_dpa   = (quo << gsh) | (hpa_q & lo_mask);
    end

    always_comb begin
        out_err = err_q;
        if (err_q) begin
            out_pos = '0;
            out_dpa = '1;
        end else if (winfo_q.three) begin
            out_pos = t_pos;
            out_dpa = t_dpa;
        end else begin
            out_pos = p2_pos;
            out_dpa = p2_dpa;
        end
    end

    // checker-only cycle counter since the last accept
    logic [CNT_W:0] since_acc;
    always_ff @(posedge clk) begin
        if (rst)                    since_acc <= '0;
        else if (accept)            since_acc <= '0;
        else if (state != ST_IDLE)  since_acc <= since_acc + 1'b1;
    end

    a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        accept |=> !in_ready);

    a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    a_r2_fixed_latency: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> since_acc == (CNT_W+1)'(ITER));

    a_r3_low_bits_kept: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_err) |-> ((out_dpa & lo_mask) == (hpa_q & lo_mask)));

    a_r7_pos_in_range: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_err) |-> ({1'b0, out_pos} < way_count(winfo_q)));

    a_r11_hold_result: assert property (@(posedge clk) disable iff (rst)
        ($past(state) == ST_IDLE && !$past(accept)) |-> $stable(out_dpa));

endmodule

// File: tb/ilv_decoder_test.sv
module ilv_decoder_test;
    import ilvd_pkg::*;

    localparam int AW  = 52;
    localparam int LAT = 13;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [AW-1:0] in_hpa = '0;
    logic [3:0]    in_eiw = '0;
    logic [3:0]    in_eig = '0;
    logic          out_valid;
    logic          out_err;
    logic [3:0]    out_pos;
    logic [AW-1:0] out_dpa;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    ilv_decoder uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_hpa(in_hpa), .in_eiw(in_eiw), .in_eig(in_eig),
        .out_valid(out_valid), .out_err(out_err), .out_pos(out_pos),
        .out_dpa(out_dpa)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // independent reference model
    task automatic model(input logic [63:0] h, input int eiw, input int eig,
                         output logic e, output logic [63:0] pos, output logic [63:0] dpa);
        logic [63:0] ways, low, gs;
        e = 1'b0; ways = 0;
        if (eiw <= 4)                 ways = 64'd1 << eiw;
        else if (eiw >= 8 && eiw <= 10) ways = 64'd3 << (eiw - 8);
        else                          e = 1'b1;
        if (eig > 6) e = 1'b1;
        if (e) begin
            pos = 0;
            dpa = {12'h0, {AW{1'b1}}};
        end else begin
            gs  = 64'(eig + 8);
            low = h & ((64'd1 << gs) - 1);
            pos = (h >> gs) % ways;
            if (eiw <= 4) dpa = ((h >> (gs + 64'(eiw))) << gs) | low;
            else          dpa = (((h >> (eig + eiw)) / 3) << gs) | low;
            dpa = dpa & {12'h0, {AW{1'b1}}};
        end
    endtask

    task automatic run_req(input string req, input logic [AW-1:0] h, input int eiw, input int eig);
        logic e; logic [63:0] ep, ed;
        int n;
        model({12'h0, h}, eiw, eig, e, ep, ed);
        @(negedge clk);
        in_valid = 1'b1; in_hpa = h; in_eiw = 4'(eiw); in_eig = 4'(eig);
        chk({req, "/R1 ready before accept"}, 64'(in_ready), 64'd1);
        @(negedge clk);
        in_valid = 1'b0;
        n = 0;
        while (!out_valid && n < 40) begin
            @(negedge clk);
            n++;
        end
        chk({req, "/R2 latency"}, 64'(n), 64'(LAT));
        chk({req, "/R1 not ready in done"}, 64'(in_ready), 64'd0);
        chk({req, " err"}, 64'(out_err), 64'(e));
        chk({req, " pos"}, 64'(out_pos), ep);
        chk({req, " dpa"}, 64'(out_dpa), ed);
        @(negedge clk);
        chk({req, "/R2 pulse ends"}, 64'(out_valid), 64'd0);
        chk({req, "/R1 ready again"}, 64'(in_ready), 64'd1);
    endtask

    task automatic t_reset();
        chk("R1 reset ready", 64'(in_ready), 64'd1);
        chk("R1 reset valid", 64'(out_valid), 64'd0);
    endtask

    task automatic t_pow2();
        run_req("R6 one way", 52'hA_5F3C_9E71_2468, 0, 2);
        run_req("R4 R5 R3 two way", 52'h3_1234_5678_9ABC, 1, 0);
        run_req("R4 R5 four way", 52'hF_EDCB_A987_6543, 2, 3);
        run_req("R4 R5 eight way", 52'h0_0000_0001_F3C0, 3, 1);
        run_req("R4 R5 R3 sixteen way", 52'hF_FFFF_FFFF_FFFF, 4, 6);
    endtask

    task automatic t_three();
        run_req("R7 R8 three way", 52'h7_89AB_CDEF_0123, 8, 0);
        run_req("R7 R8 six way", 52'hC_0FFE_E123_4567, 9, 3);
        run_req("R7 R8 twelve way", 52'hF_FFFF_FFFF_FFFF, 10, 6);
        run_req("R7 R8 small offset", 52'h0_0000_0000_0B00, 10, 0);
    endtask

    task automatic t_invalid();
        run_req("R9 eiw 5", 52'h1_2345_6789_ABCD, 5, 0);
        run_req("R9 eiw 11", 52'h1_2345_6789_ABCD, 11, 2);
        run_req("R9 eiw 15", 52'h0, 15, 0);
        run_req("R10 eig 7", 52'h1_2345_6789_ABCD, 1, 7);
        run_req("R10 eig 15", 52'h1_2345_6789_ABCD, 9, 15);
    endtask

    task automatic t_busy_hold();
        logic e; logic [63:0] ep, ed;
        model(64'h0000_9_8765_4321_0FED, 9, 2, e, ep, ed);
        @(negedge clk);
        in_valid = 1'b1; in_hpa = 52'h9_8765_4321_0FED; in_eiw = 4'd9; in_eig = 4'd2;
        @(negedge clk);
        in_hpa = 52'h1_1111_1111_1111; in_eiw = 4'd2; in_eig = 4'd0;
        for (int i = 0; i < 5; i++) begin
            chk("R11 busy ready low", 64'(in_ready), 64'd0);
            @(negedge clk);
        end
        in_valid = 1'b0;
        for (int i = 5; i < LAT; i++) @(negedge clk);
        chk("R11 busy done", 64'(out_valid), 64'd1);
        chk("R11 busy pos", 64'(out_pos), ep);
        chk("R11 busy dpa", 64'(out_dpa), ed);
        for (int i = 0; i < 4; i++) @(negedge clk);
        chk("R11 hold pos", 64'(out_pos), ep);
        chk("R11 hold dpa", 64'(out_dpa), ed);
        chk("R11 hold err", 64'(out_err), 64'(e));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_pow2();
        t_three();
        t_invalid();
        t_busy_hold();
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule